// File: doc/BRIEF.md
# Parallel-Bus Sampling Converter Digital Interface

This block is the digital side of a twelve-bit, eight-channel sampling converter that talks to a host over a parallel bus. A falling edge on the active-low start strobe freezes the test sample value and its channel number. It then runs a conversion of fixed length, timed by master-clock ticks, and raises a busy flag for the whole of it. When the conversion ends, the frozen value and channel are moved into an output register and busy drops.

The host uses active-low chip-select, read and write strobes. In word mode all twelve bus bits carry data. In byte mode, bus bit 8 turns into a high-half select. With that select low, the low eight result bits travel on bits 0 to 7. With it high, the top four result bits travel on bits 0 to 3 and the channel number on bits 4 to 6. Writes load a control register in the same two ways. The two low control bits choose a power policy. In an automatic power-down policy the converter goes to sleep after each conversion, and a rising edge on the start strobe wakes it.

The master clock arrives as a one-cycle tick enable in the system clock domain, so it may run continuously or in bursts. All strobes are taken to be synchronous to the system clock.

Top module: `adc_par_bus`

## Requirements
- R1: After reset, busy, wr_err and bus_oe are low, ctrl_q and the output register are zero, and powered is high.
- R2: A falling edge of convst_n that is sampled while powered is high and busy is low makes busy high from the next cycle. A falling edge sampled while busy is high has no effect on the running conversion.
- R3: Busy stays high until CONV_TICKS master-clock ticks (mclk_en high at an edge while converting) have been counted, and then for TAIL_CYCLES more clock cycles. Busy falls on the same edge that loads the output register.
- R4: bus_oe is high only while cs_n and rd_n are both low. Otherwise it is low and bus_out reads zero.
- R5: A read in word mode (word_mode=1) returns the 12-bit result on bus_out[11:0].
- R6: A read in byte mode (word_mode=0) with bus_in[8]=0 returns result[7:0] on bus_out[7:0], with bus_out[11:8] zero.
- R7: A read in byte mode with bus_in[8]=1 returns result[11:8] on bus_out[3:0] and the result's channel on bus_out[6:4], with all other bits zero.
- R8: A word-mode write loads ctrl_q from bus_in[11:0] on the first cycle that cs_n and wr_n are both low. Later cycles of the same strobe load nothing.
- R9: A byte-mode write with bus_in[8]=0 loads ctrl_q[7:0] from bus_in[7:0]. With bus_in[8]=1 and bus_in[7:4]=0, it loads ctrl_q[11:8] from bus_in[3:0].
- R10: A byte-mode high-half write with any of bus_in[7:4] set leaves ctrl_q unchanged and pulses wr_err for one cycle.
- R11: A write accepted while busy is high updates ctrl_q and does not shorten, lengthen or abort the conversion.
- R12: With ctrl_q[1]=1 (automatic power-down), powered falls when a conversion completes. While powered is low, a falling convst_n starts nothing. A rising convst_n sets powered high on the next cycle. With ctrl_q[1]=0, powered is held high.
- R13: The value and channel stored at completion are those on samp_code and samp_chan at the start edge. Changes to them during the conversion are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_en | input | 1 | Master-clock tick, one cycle per master-clock period |
| convst_n | input | 1 | Active-low conversion start; a rising edge wakes the converter |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| word_mode | input | 1 | 1 = 12-bit word bus, 0 = byte bus with high-half select on bit 8 |
| bus_in | input | RES_W | Bus input side; bit 8 is the high-half select in byte mode |
| bus_out | output | RES_W | Bus output side |
| bus_oe | output | 1 | Bus output enable (low = tri-stated) |
| busy | output | 1 | Conversion in progress |
| powered | output | 1 | Converter awake and able to start |
| wr_err | output | 1 | One-cycle pulse on a rejected high-half write |
| ctrl_q | output | RES_W | Control register contents |
| samp_code | input | RES_W | Test value standing in for the analog sample |
| samp_chan | input | CH_W | Channel of the test value |

## Verification
The bench uses the default parameters: a 12-bit result, a 3-bit channel, 13 ticks and a 2-cycle tail. With these, the full byte-mode packing can be checked, including the high half with the channel in bits 4 to 6. The real conversion length can also be checked, at 15 cycles for a continuous tick and at 12·gap+3 cycles for ticks spaced gap cycles apart. The short tail lets the bench aim a write and a second start edge into the middle of a conversion, and reach the power-down and wake sequence, in a few dozen cycles.

// File: rtl/adc_bus_pkg.sv
// Package: shared constants and types for the parallel-bus converter interface.
// Assumes: results no wider than 16 bits and byte lanes of 8 bits.
package adc_bus_pkg;

    localparam int BYTE_W = 8;

    // Conversion sequencer phases
    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_RUN  = 2'd1,
        CV_TAIL = 2'd2
    } conv_state_t;

    // Power policy field held in the low control bits
    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_NORMAL2 = 2'b01,
        PWR_AUTO_SD = 2'b10,
        PWR_AUTO_SB = 2'b11
    } pwr_mode_t;

    // True when the policy sleeps the converter after each conversion
    function automatic logic pwr_is_auto(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/adc_strobe_edge.sv
// Module: registers a level and reports its rising and falling edges.
// Assumes: the level is synchronous to clk; IDLE_LEVEL is the value the
// history register takes in reset, so no edge is seen straight after reset.
module adc_strobe_edge #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rose,
    output logic fell
);

    logic prev_q;

    // Keep last cycle's level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= IDLE_LEVEL;
        end else begin
            prev_q <= level;
        end
    end

    assign rose = level & ~prev_q;
    assign fell = ~level & prev_q;

endmodule

// File: rtl/adc_conv_timer.sv
// Module: conversion sequencer. It freezes sample and channel on a start
// edge, counts CONV_TICKS master ticks, waits TAIL_CYCLES clocks, and then
// loads the output register. It also tracks the awake/asleep power state.
// Assumes: CONV_TICKS >= 1 and TAIL_CYCLES >= 1.
module adc_conv_timer
    import adc_bus_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CH_W        = 3,
    parameter int CONV_TICKS  = 13,
    parameter int TAIL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_en,
    input  logic             start_fall,
    input  logic             start_rise,
    input  logic             auto_pd,
    input  logic [RES_W-1:0] samp_code,
    input  logic [CH_W-1:0]  samp_chan,
    output logic             busy,
    output logic             awake,
    output logic [RES_W-1:0] res_code,
    output logic [CH_W-1:0]  res_chan
);

    localparam int TICK_W = (CONV_TICKS  > 1) ? $clog2(CONV_TICKS)  : 1;
    localparam int TAIL_W = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CONV_TICKS - 1);
    localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(TAIL_CYCLES - 1);

    conv_state_t       state_q;
    logic [TICK_W-1:0] tick_q;
    logic [TAIL_W-1:0] tail_q;
    logic [RES_W-1:0]  hold_code_q;
    logic [CH_W-1:0]   hold_chan_q;
    logic              launch;
    logic              finish;

    assign launch = (state_q == CV_IDLE) && start_fall && awake;
    assign finish = (state_q == CV_TAIL) && (tail_q == TAIL_LAST);
    assign busy   = (state_q != CV_IDLE);

    // Phase sequencing and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            tick_q  <= '0;
            tail_q  <= '0;
        end else begin
            case (state_q)
                CV_IDLE: begin
                    if (launch) begin
                        state_q <= CV_RUN;
                        tick_q  <= '0;
                    end
                end
                CV_RUN: begin
                    if (mclk_en) begin
                        if (tick_q == TICK_LAST) begin
                            state_q <= CV_TAIL;
                            tail_q  <= '0;
                        end else begin
                            tick_q <= tick_q + 1'b1;
                        end
                    end
                end
                CV_TAIL: begin
                    if (finish) begin
                        state_q <= CV_IDLE;
                    end else begin
                        tail_q <= tail_q + 1'b1;
                    end
                end
                default: state_q <= CV_IDLE;
            endcase
        end
    end

    // Freeze sample and channel at the start edge (hold mode)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_code_q <= '0;
            hold_chan_q <= '0;
        end else if (launch) begin
            hold_code_q <= samp_code;
            hold_chan_q <= samp_chan;
        end
    end

    // Output register loads on the edge where busy drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code <= '0;
            res_chan <= '0;
        end else if (finish) begin
            res_code <= hold_code_q;
            res_chan <= hold_chan_q;
        end
    end

    // Power state: sleep after a conversion under auto policy, wake on rising start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake <= 1'b1;
        end else if (!auto_pd) begin
            awake <= 1'b1;
        end else if (start_rise && !busy) begin
            awake <= 1'b1;
        end else if (finish) begin
            awake <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_ctrl_reg.sv
// Module: control register write port. It takes whole-word writes or
// byte-lane writes, and rejects high-half writes whose upper nibble is nonzero.
// Assumes: wr_go is a single-cycle pulse at the start of a write strobe.
module adc_ctrl_reg
    import adc_bus_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic             word_mode,
    input  logic [RES_W-1:0] bus_in,
    output logic [RES_W-1:0] ctrl_q,
    output logic             wr_err
);

    localparam int HI_W = RES_W - BYTE_W;

    logic hben;
    logic hi_bad;

    assign hben   = bus_in[BYTE_W];
    assign hi_bad = !word_mode && hben && (|bus_in[BYTE_W-1:HI_W]);

    // Register update by bus mode and lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_go) begin
            if (word_mode) begin
                ctrl_q <= bus_in;
            end else if (!hben) begin
                ctrl_q[BYTE_W-1:0] <= bus_in[BYTE_W-1:0];
            end else if (!hi_bad) begin
                ctrl_q[RES_W-1:BYTE_W] <= bus_in[HI_W-1:0];
            end
        end
    end

    // Flag a rejected high-half write for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_go && hi_bad;
        end
    end

endmodule

// File: rtl/adc_read_mux.sv
// Module: formats the output register onto the bus for word, low-half and
// high-half reads, and drives the output enable.
// Assumes: HI_W + CH_W fits in one byte lane.
module adc_read_mux
    import adc_bus_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             word_mode,
    input  logic             hben,
    input  logic [RES_W-1:0] res_code,
    input  logic [CH_W-1:0]  res_chan,
    output logic [RES_W-1:0] bus_out,
    output logic             bus_oe
);

    localparam int HI_W = RES_W - BYTE_W;

    logic [BYTE_W-1:0] hi_lane;
    logic [RES_W-1:0]  word_val;

    // High lane: upper result bits then channel tag
    always_comb begin
        hi_lane = '0;
        hi_lane[HI_W-1:0]     = res_code[RES_W-1:BYTE_W];
        hi_lane[HI_W +: CH_W] = res_chan;
    end

    // Select the read format and gate it by the strobes
    always_comb begin
        word_val = '0;
        if (word_mode) begin
            word_val = res_code;
        end else if (hben) begin
            word_val[BYTE_W-1:0] = hi_lane;
        end else begin
            word_val[BYTE_W-1:0] = res_code[BYTE_W-1:0];
        end
        bus_oe  = !cs_n && !rd_n;
        bus_out = bus_oe ? word_val : '0;
    end

endmodule

// File: rtl/adc_par_bus.sv
// Module: top of the parallel-bus converter interface. It joins strobe edge
// detection, the conversion sequencer, the control register and the read formatter.
// Assumes: all inputs are synchronous to clk; mclk_en marks master-clock ticks.
module adc_par_bus
    import adc_bus_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CH_W        = 3,
    parameter int CONV_TICKS  = 13,
    parameter int TAIL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_en,
    input  logic             convst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             word_mode,
    input  logic [RES_W-1:0] bus_in,
    output logic [RES_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             busy,
    output logic             powered,
    output logic             wr_err,
    output logic [RES_W-1:0] ctrl_q,
    input  logic [RES_W-1:0] samp_code,
    input  logic [CH_W-1:0]  samp_chan
);

    logic             cv_rise;
    logic             cv_fall;
    logic             wr_act;
    logic             wr_go;
    logic             wr_end;
    logic [RES_W-1:0] res_code;
    logic [CH_W-1:0]  res_chan;

    assign wr_act = !cs_n && !wr_n;

    adc_strobe_edge #(.IDLE_LEVEL(1'b1)) u_cv_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (convst_n),
        .rose  (cv_rise),
        .fell  (cv_fall)
    );

    adc_strobe_edge #(.IDLE_LEVEL(1'b0)) u_wr_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (wr_act),
        .rose  (wr_go),
        .fell  (wr_end)
    );

    adc_conv_timer #(
        .RES_W       (RES_W),
        .CH_W        (CH_W),
        .CONV_TICKS  (CONV_TICKS),
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_en    (mclk_en),
        .start_fall (cv_fall),
        .start_rise (cv_rise),
        .auto_pd    (pwr_is_auto(ctrl_q[1:0])),
        .samp_code  (samp_code),
        .samp_chan  (samp_chan),
        .busy       (busy),
        .awake      (powered),
        .res_code   (res_code),
        .res_chan   (res_chan)
    );

    adc_ctrl_reg #(.RES_W(RES_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .word_mode (word_mode),
        .bus_in    (bus_in),
        .ctrl_q    (ctrl_q),
        .wr_err    (wr_err)
    );

    adc_read_mux #(.RES_W(RES_W), .CH_W(CH_W)) u_rdmux (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .word_mode (word_mode),
        .hben      (bus_in[BYTE_W]),
        .res_code  (res_code),
        .res_chan  (res_chan),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    // The end of a write strobe needs no action
    logic unused_ok;
    assign unused_ok = wr_end;

endmodule

// File: rtl/adc_par_bus_chk.sv
// Module: checker for adc_par_bus, bound to every instance of the top.
// Assumes: the same parameters as the top it is bound to.
module adc_par_bus_chk #(
    parameter int RES_W      = 12,
    parameter int CONV_TICKS = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mclk_en,
    input logic             convst_n,
    input logic             cs_n,
    input logic             bus_oe,
    input logic             busy,
    input logic             powered,
    input logic             wr_err,
    input logic [RES_W-1:0] ctrl_q
);

    localparam int CW = $clog2(CONV_TICKS + 1);

    logic          cv_prev;
    logic [CW-1:0] ticks;

    // Track the start strobe for edge checks
    always_ff @(posedge clk) begin
        if (!rst_n) cv_prev <= 1'b1;
        else        cv_prev <= convst_n;
    end

    // Count master ticks seen while busy, saturating at the target
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)                          ticks <= '0;
        else if (mclk_en && ticks < CW'(CONV_TICKS))  ticks <= ticks + 1'b1;
    end

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_prev && !convst_n && powered && !busy) |=> busy);

    // R3
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ticks == CW'(CONV_TICKS)));

    // R4
    bus_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    // R10
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $stable(ctrl_q));

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> !wr_err);

    // R12
    asleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |-> !busy);

endmodule

bind adc_par_bus adc_par_bus_chk #(
    .RES_W      (RES_W),
    .CONV_TICKS (CONV_TICKS)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclk_en  (mclk_en),
    .convst_n (convst_n),
    .cs_n     (cs_n),
    .bus_oe   (bus_oe),
    .busy     (busy),
    .powered  (powered),
    .wr_err   (wr_err),
    .ctrl_q   (ctrl_q)
);

// File: tb/test_adc_par_bus.sv
`timescale 1ns/1ps
module test_adc_par_bus;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclk_en = 1'b0;
    logic        convst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        word_mode = 1'b1;
    logic [11:0] bus_in = '0;
    logic [11:0] bus_out;
    logic        bus_oe;
    logic        busy;
    logic        powered;
    logic        wr_err;
    logic [11:0] ctrl_q;
    logic [11:0] samp_code = '0;
    logic [2:0]  samp_chan = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    adc_par_bus i_adc_par_bus (
        .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .convst_n(convst_n),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .word_mode(word_mode),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy),
        .powered(powered), .wr_err(wr_err), .ctrl_q(ctrl_q),
        .samp_code(samp_code), .samp_chan(samp_chan)
    );

    // {gap[1:0], word_mode, hben, value[11:0], chan[2:0], expected bus[11:0]}
    localparam logic [30:0] VECS [0:7] = '{
        {2'd1, 1'b1, 1'b1, 12'hA5C, 3'd3, 12'hA5C},
        {2'd2, 1'b0, 1'b0, 12'hA5C, 3'd3, 12'h05C},
        {2'd1, 1'b0, 1'b1, 12'hA5C, 3'd3, 12'h03A},
        {2'd3, 1'b0, 1'b1, 12'hFFF, 3'd7, 12'h07F},
        {2'd1, 1'b0, 1'b0, 12'h0FF, 3'd0, 12'h0FF},
        {2'd2, 1'b1, 1'b0, 12'h000, 3'd5, 12'h000},
        {2'd1, 1'b0, 1'b1, 12'h123, 3'd5, 12'h051},
        {2'd1, 1'b1, 1'b0, 12'h800, 3'd6, 12'h800}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start a conversion, scramble the sample inputs, tick every gap cycles,
    // optionally write and re-strobe start mid-conversion; return busy cycles
    task automatic run_conv(input logic [11:0] v, input logic [2:0] ch,
                            input int gap, input bit poke, output int hi);
        int k;
        @(negedge clk); samp_code = v; samp_chan = ch; convst_n = 1'b0;
        @(negedge clk); convst_n = 1'b1; samp_code = ~v; samp_chan = ~ch;
        hi = 0; k = 1;
        while (busy && k < 1000) begin
            hi++;
            mclk_en = ((k - 1) % gap == 0);
            if (poke && k == 3) begin
                word_mode = 1'b1; bus_in = 12'h0A0; cs_n = 1'b0; wr_n = 1'b0; convst_n = 1'b0;
            end
            if (poke && k == 4) begin
                cs_n = 1'b1; wr_n = 1'b1; convst_n = 1'b1;
            end
            @(negedge clk); k++;
        end
        mclk_en = 1'b0;
    endtask

    task automatic do_read(input logic wm, input logic hb, input logic [11:0] exp, input string req);
        @(negedge clk); word_mode = wm; bus_in = '0; bus_in[8] = hb; cs_n = 1'b0; rd_n = 1'b0;
        #1; chk("R4 oe during read", {31'd0, bus_oe}, 32'd1); chk(req, {20'd0, bus_out}, {20'd0, exp});
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        #1; chk("R4 oe after read", {31'd0, bus_oe}, 32'd0);
    endtask

    // Two-cycle write strobe; the second cycle carries different data
    task automatic do_write(input logic wm, input logic [11:0] d, output logic err);
        @(negedge clk); word_mode = wm; bus_in = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); err = wr_err; bus_in = d ^ 12'h0F1;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1; bus_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R3 watchdog actual=hung expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hi;
        logic err;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 wr_err", {31'd0, wr_err}, 32'd0);
        chk("R1 ctrl", {20'd0, ctrl_q}, 32'd0);
        chk("R1 powered", {31'd0, powered}, 32'd1);
        chk("R1 oe", {31'd0, bus_oe}, 32'd0);
        rst_n = 1'b1;
        do_read(1'b1, 1'b0, 12'h000, "R1 result after reset");

        // R4 read strobe with chip select high
        @(negedge clk); rd_n = 1'b0; #1;
        chk("R4 cs high", {31'd0, bus_oe}, 32'd0);
        chk("R4 bus zero", {20'd0, bus_out}, 32'd0);
        @(negedge clk); rd_n = 1'b1;

        // Vector table: R3 length, R5/R6/R7 formats, R13 frozen sample
        for (int i = 0; i < 8; i++) begin
            run_conv(VECS[i][26:15], VECS[i][14:12], int'(VECS[i][30:29]), 1'b0, hi);
            chk("R3 busy length", hi, 12 * int'(VECS[i][30:29]) + 3);
            do_read(VECS[i][28], VECS[i][27], VECS[i][11:0],
                    VECS[i][28] ? "R5 word read R13" : (VECS[i][27] ? "R7 high read R13" : "R6 low read R13"));
        end

        // R2 restart ignored and R11 write while busy
        run_conv(12'h3C3, 3'd2, 1, 1'b1, hi);
        chk("R2 R11 busy length unchanged", hi, 15);
        chk("R11 ctrl written while busy", {20'd0, ctrl_q}, 32'h0A0);
        do_read(1'b1, 1'b0, 12'h3C3, "R2 R13 result kept");

        // R8 word write, first strobe cycle only
        do_write(1'b1, 12'h7E4, err);
        chk("R8 word write", {20'd0, ctrl_q}, 32'h7E4);
        // R9 byte lanes
        do_write(1'b0, 12'h05C, err);
        chk("R9 low lane", {20'd0, ctrl_q}, 32'h75C);
        do_write(1'b0, 12'h106, err);
        chk("R9 high lane", {20'd0, ctrl_q}, 32'h65C);
        chk("R9 no error", {31'd0, err}, 32'd0);
        // R10 rejected high write
        do_write(1'b0, 12'h136, err);
        chk("R10 error pulse", {31'd0, err}, 32'd1);
        chk("R10 ctrl unchanged", {20'd0, ctrl_q}, 32'h65C);
        chk("R10 error cleared", {31'd0, wr_err}, 32'd0);

        // R12 automatic power-down and wake
        do_write(1'b1, 12'h002, err);
        chk("R12 awake before conversion", {31'd0, powered}, 32'd1);
        run_conv(12'h456, 3'd1, 1, 1'b0, hi);
        chk("R12 conversion length", hi, 15);
        chk("R12 asleep after", {31'd0, powered}, 32'd0);
        @(negedge clk); convst_n = 1'b0; samp_code = 12'h999;
        @(negedge clk);
        chk("R12 no start while asleep", {31'd0, busy}, 32'd0);
        convst_n = 1'b1;
        @(negedge clk);
        chk("R12 woken by rising start", {31'd0, powered}, 32'd1);
        do_read(1'b1, 1'b0, 12'h456, "R12 result kept while asleep");
        run_conv(12'h789, 3'd4, 1, 1'b0, hi);
        chk("R12 conversion after wake", hi, 15);
        do_read(1'b0, 1'b1, 12'h047, "R7 R12 high read after wake");
        do_write(1'b1, 12'h000, err);
        chk("R12 normal policy awake", {31'd0, powered}, 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule